// File: doc/BRIEF.md
# Voice Controller Serial Command Decoder

This block is the serial front end of a voice record and playback controller. It listens on a two-wire I2C bus as a write-only slave. It answers only to its own device address. After that it takes one command byte and, when the command needs them, two message address bytes. It pulls the data line low to acknowledge each byte it accepts.

Once the last byte a command needs has been acknowledged, the block does two things. It raises a single-cycle action strobe for the storage engine, and for commands that carry an address it loads the 16-bit message pointer. There are four commands. One only sets the pointer. One starts playback at the pointer already held. One sets the pointer and starts playback. One sets the pointer and starts recording.

Both bus lines pass through a synchroniser before any edge is detected. A data transition while the clock is high is a bus condition: a falling one is START and a rising one is STOP. A STOP or a repeated START that arrives before a command is complete throws the partial command away.

Top module: `voice_cmd_i2c`

## Requirements
- R1: The device byte 80h (7-bit address 40h, write) is acknowledged. Any other device byte, including 81h with the read bit set, is not acknowledged. The rest of that transfer produces no acknowledge, no strobe and no pointer change.
- R2: Command 81h followed by two bytes acknowledges all four bytes. It sets the pointer to {first byte, second byte}, where the first byte is the high half and each byte arrives MSB first. It pulses only `loadStb`.
- R3: Command A8h has no operand bytes. After its acknowledge it pulses `playStb`, and the pointer keeps its value.
- R4: Command A9h followed by two bytes sets the pointer as in R2 and pulses `playAtStb`.
- R5: Command 91h followed by two bytes sets the pointer as in R2 and pulses `recStb`.
- R6: Each strobe is high for exactly one clock cycle, and at most one strobe is high at a time. A strobe rises only after the falling clock edge that ends the acknowledge of the command's final byte. The pointer update appears in that same cycle.
- R7: A STOP received before all operand bytes of a command gives no strobe and leaves the pointer unchanged.
- R8: A command byte other than 81h, A8h, A9h or 91h is not acknowledged. No further byte is acknowledged until the next START.
- R9: A repeated START in the middle of a command drops the partial command. The transfer that follows is decoded from its device byte as normal.
- R10: After reset the pointer is 0000h, all strobes are low and the data line is released (`sdaPull` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPull | output | 1 | When high, the open-drain data line is pulled low (acknowledge) |
| msgPtr | output | 16 | Current message pointer for the storage engine |
| loadStb | output | 1 | One-cycle pulse: pointer loaded, no action |
| playStb | output | 1 | One-cycle pulse: start playback at current pointer |
| playAtStb | output | 1 | One-cycle pulse: pointer loaded, start playback |
| recStb | output | 1 | One-cycle pulse: pointer loaded, start recording |

## Verification
The bench aims at three things: transfers that stop short, a repeated START that lands between operand bytes, and a device byte carrying the read bit. A decoder that committed the high byte too early, or that ignored a mid-command START, would show a changed pointer or a strobe from the abandoned command. The bench also sends bytes after a rejected command or address. A decoder that forgot its rejection would acknowledge one of these or fire a strobe. Every strobe is matched against an expected queue that holds its kind and pointer. A strobe that fired early, lasted two cycles or was never expected therefore shows up as a mismatch or as a strobe with no queued entry.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_LOAD   = 8'h81;
  localparam logic [BYTE_W-1:0] OP_PLAY   = 8'hA8;
  localparam logic [BYTE_W-1:0] OP_PLAYAT = 8'hA9;
  localparam logic [BYTE_W-1:0] OP_REC    = 8'h91;

  // control -> datapath strobes
  typedef struct packed {
    logic ackNow;     // drive acknowledge for the byte just received
    logic grabHi;     // hold received byte as pointer high half
    logic commitPtr;  // load pointer from {high half, received byte}
  } dpCtl_t;

  typedef struct packed {
    logic rec;
    logic playAt;
    logic play;
    logic load;
  } actStb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_CMD, ST_HI, ST_LO, ST_FIRE
  } ctlState_e;
endpackage

// File: rtl/vc_i2c_dp.sv
module vc_i2c_dp
  import vc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              byteReady,
  output logic              ackEnd,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaPull,
  output logic [PTR_W-1:0]  msgPtr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall;
  logic [CNT_W-1:0] bitCnt;
  logic ackPhase;
  logic [BYTE_W-1:0] hiReg;

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign byteReady = ~ackPhase & sclFall & (bitCnt == CNT_W'(BYTE_W));
  assign ackEnd    = ackPhase & sclFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      sdaPull  <= 1'b0;
      rxByte   <= '0;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
      if (startSeen || stopSeen) begin
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        sdaPull  <= 1'b0;
      end else if (byteReady) begin
        bitCnt   <= '0;
        ackPhase <= 1'b1;
        sdaPull  <= ctl.ackNow;
      end else if (ackEnd) begin
        ackPhase <= 1'b0;
        sdaPull  <= 1'b0;
      end else if (!ackPhase && sclRise && bitCnt < CNT_W'(BYTE_W)) begin
        rxByte <= {rxByte[BYTE_W-2:0], sdaS};
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg  <= '0;
      msgPtr <= '0;
    end else begin
      if (ctl.grabHi)    hiReg  <= rxByte;
      if (ctl.commitPtr) msgPtr <= {hiReg, rxByte};
    end
  end

  // R1
  ack_only_on_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPull) |-> $past(byteReady && ctl.ackNow));

  // R7
  ptr_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgPtr != $past(msgPtr)) |-> $past(ctl.commitPtr));
endmodule

// File: rtl/vc_i2c_ctrl.sv
module vc_i2c_ctrl
  import vc_pkg::*;
#(
  parameter logic [7:0] DEV_BYTE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              byteReady,
  input  logic              ackEnd,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t            ctl,
  output actStb_t           stb
);
  ctlState_e state, nxt;
  logic [BYTE_W-1:0] opReg;
  logic fireNow;

  always_comb begin
    ctl     = '0;
    nxt     = state;
    fireNow = 1'b0;
    if (startSeen) begin
      nxt = ST_DEV;
    end else if (stopSeen) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_DEV: if (byteReady) begin
          if (rxByte == DEV_BYTE) begin
            ctl.ackNow = 1'b1;
            nxt = ST_CMD;
          end else begin
            nxt = ST_IDLE;
          end
        end
        ST_CMD: if (byteReady) begin
          if (rxByte == OP_LOAD || rxByte == OP_PLAYAT || rxByte == OP_REC) begin
            ctl.ackNow = 1'b1;
            nxt = ST_HI;
          end else if (rxByte == OP_PLAY) begin
            ctl.ackNow = 1'b1;
            nxt = ST_FIRE;
          end else begin
            nxt = ST_IDLE;
          end
        end
        ST_HI: if (byteReady) begin
          ctl.ackNow = 1'b1;
          ctl.grabHi = 1'b1;
          nxt = ST_LO;
        end
        ST_LO: if (byteReady) begin
          ctl.ackNow = 1'b1;
          nxt = ST_FIRE;
        end
        ST_FIRE: if (ackEnd) begin
          fireNow       = 1'b1;
          ctl.commitPtr = (opReg != OP_PLAY);
          nxt = ST_IDLE;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= '0;
      stb   <= '0;
    end else begin
      state <= nxt;
      if (state == ST_CMD && byteReady) opReg <= rxByte;
      stb.load   <= fireNow && (opReg == OP_LOAD);
      stb.play   <= fireNow && (opReg == OP_PLAY);
      stb.playAt <= fireNow && (opReg == OP_PLAYAT);
      stb.rec    <= fireNow && (opReg == OP_REC);
    end
  end

  // R6
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb) |=> !(|stb));

  // R6
  stb_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb) |-> $past(state == ST_FIRE && ackEnd));
endmodule

// File: rtl/voice_cmd_i2c.sv
module voice_cmd_i2c
  import vc_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR7   = 7'h40,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPull,
  output logic [PTR_W-1:0] msgPtr,
  output logic             loadStb,
  output logic             playStb,
  output logic             playAtStb,
  output logic             recStb
);
  localparam logic [7:0] DEV_BYTE = {DEV_ADDR7, 1'b0};

  dpCtl_t ctl;
  actStb_t stb;
  logic startSeen, stopSeen, byteReady, ackEnd;
  logic [BYTE_W-1:0] rxByte;

  vc_i2c_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .startSeen(startSeen), .stopSeen(stopSeen), .byteReady(byteReady),
    .ackEnd(ackEnd), .rxByte(rxByte), .sdaPull(sdaPull), .msgPtr(msgPtr)
  );

  vc_i2c_ctrl #(.DEV_BYTE(DEV_BYTE)) uCtrl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteReady(byteReady), .ackEnd(ackEnd), .rxByte(rxByte),
    .ctl(ctl), .stb(stb)
  );

  assign loadStb   = stb.load;
  assign playStb   = stb.play;
  assign playAtStb = stb.playAt;
  assign recStb    = stb.rec;
endmodule

// File: tb/voice_cmd_i2c_test.sv
module voice_cmd_i2c_test;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPull;
  logic [15:0] msgPtr;
  logic loadStb, playStb, playAtStb, recStb;

  int checks = 0;
  int fails = 0;
  logic fireWindow = 1'b0;

  logic [3:0]  expKind[$];
  logic [15:0] expPtr[$];
  string       expTag[$];

  always #4 clk = ~clk;  // 125 MHz

  assign sdaLine = sdaM & ~sdaPull;

  voice_cmd_i2c uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPull(sdaPull), .msgPtr(msgPtr), .loadStb(loadStb),
    .playStb(playStb), .playAtStb(playAtStb), .recStb(recStb)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    ticks(T); sdaM = 1'b1;
    ticks(T); sclM = 1'b1;
    ticks(T); sdaM = 1'b0;
    ticks(T); sclM = 1'b0;
    fireWindow = 1'b0;
  endtask

  task automatic busStop();
    ticks(T); sdaM = 1'b0;
    ticks(T); sclM = 1'b1;
    ticks(T); sdaM = 1'b1;
    ticks(4 * T);
  endtask

  // sends one byte MSB first; returns 1 when acknowledged
  task automatic sendByte(input logic [7:0] b, input logic last, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      ticks(T); sdaM = b[i];
      ticks(T); sclM = 1'b1;
      ticks(2 * T); sclM = 1'b0;
    end
    ticks(T); sdaM = 1'b1;
    ticks(T); sclM = 1'b1;
    ticks(T); acked = ~sdaLine;
    ticks(T);
    if (last) fireWindow = 1'b1;
    sclM = 1'b0;
  endtask

  task automatic expectAck(input logic [7:0] b, input logic last, input logic want, input string tag);
    logic a;
    sendByte(b, last, a);
    check(a == want, tag, a, want);
  endtask

  task automatic pushExp(input logic [3:0] kind, input logic [15:0] p, input string tag);
    expKind.push_back(kind);
    expPtr.push_back(p);
    expTag.push_back(tag);
  endtask

  // scoreboard monitor; kind bits {rec, playAt, play, load}
  always @(negedge clk) begin
    if (rstN && (loadStb | playStb | playAtStb | recStb)) begin
      logic [3:0] got;
      got = {recStb, playAtStb, playStb, loadStb};
      if (expKind.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", got, 0);
      end else begin
        logic [3:0] k;
        logic [15:0] p;
        string tg;
        k = expKind.pop_front();
        p = expPtr.pop_front();
        tg = expTag.pop_front();
        check(got == k, {tg, " strobe kind"}, got, k);
        check(msgPtr == p, {tg, " pointer"}, msgPtr, p);
        check(fireWindow, "R6 strobe before final ack", 0, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    ticks(5);
    // R10 reset state
    check(msgPtr == 16'h0000, "R10 pointer", msgPtr, 0);
    check({loadStb, playStb, playAtStb, recStb} == 4'b0, "R10 strobes", 0, 0);
    check(sdaPull == 1'b0, "R10 sda released", sdaPull, 0);
    rstN = 1'b1;
    ticks(4 * T);

    // R2 load pointer only
    pushExp(4'b0001, 16'h1234, "R2");
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'h81, 0, 1, "R2 cmd ack");
    expectAck(8'h12, 0, 1, "R2 hi ack");
    expectAck(8'h34, 1, 1, "R2 lo ack");
    busStop();
    check(msgPtr == 16'h1234, "R2 pointer after stop", msgPtr, 16'h1234);

    // R3 play from held pointer
    pushExp(4'b0010, 16'h1234, "R3");
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'hA8, 1, 1, "R3 cmd ack");
    busStop();

    // R4 play at address
    pushExp(4'b0100, 16'hABCD, "R4");
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'hA9, 0, 1, "R4 cmd ack");
    expectAck(8'hAB, 0, 1, "R4 hi ack");
    expectAck(8'hCD, 1, 1, "R4 lo ack");
    busStop();

    // R5 record at address
    pushExp(4'b1000, 16'h5A0F, "R5");
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'h91, 0, 1, "R5 cmd ack");
    expectAck(8'h5A, 0, 1, "R5 hi ack");
    expectAck(8'h0F, 1, 1, "R5 lo ack");
    busStop();

    // R1 foreign address, then read bit
    busStart();
    expectAck(8'h42, 0, 0, "R1 foreign address nack");
    expectAck(8'hA8, 0, 0, "R1 ignored byte nack");
    busStop();
    busStart();
    expectAck(8'h81, 0, 0, "R1 read bit nack");
    expectAck(8'h91, 0, 0, "R1 ignored byte nack");
    expectAck(8'h00, 0, 0, "R1 ignored byte nack");
    busStop();
    check(msgPtr == 16'h5A0F, "R1 pointer unchanged", msgPtr, 16'h5A0F);

    // R8 unknown command
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'h55, 0, 0, "R8 unknown cmd nack");
    expectAck(8'h77, 0, 0, "R8 trailing byte nack");
    expectAck(8'h88, 0, 0, "R8 trailing byte nack");
    busStop();
    check(msgPtr == 16'h5A0F, "R8 pointer unchanged", msgPtr, 16'h5A0F);

    // R7 early stop after high byte, and after command
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'hA9, 0, 1, "R7 cmd ack");
    expectAck(8'h11, 0, 1, "R7 hi ack");
    busStop();
    check(msgPtr == 16'h5A0F, "R7 pointer after early stop", msgPtr, 16'h5A0F);
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'h81, 0, 1, "R7 cmd ack");
    busStop();
    check(msgPtr == 16'h5A0F, "R7 pointer after bare command", msgPtr, 16'h5A0F);

    // R9 repeated start mid command
    pushExp(4'b0100, 16'h3344, "R9");
    busStart();
    expectAck(8'h80, 0, 1, "R1 device byte");
    expectAck(8'h91, 0, 1, "R9 first cmd ack");
    expectAck(8'h22, 0, 1, "R9 partial hi ack");
    busStart();
    expectAck(8'h80, 0, 1, "R9 device byte after restart");
    expectAck(8'hA9, 0, 1, "R9 cmd ack");
    expectAck(8'h33, 0, 1, "R9 hi ack");
    expectAck(8'h44, 1, 1, "R9 lo ack");
    busStop();
    check(msgPtr == 16'h3344, "R9 pointer", msgPtr, 16'h3344);

    ticks(8 * T);
    check(expKind.size() == 0, "R6 missing strobes", expKind.size(), 0);
    check(sdaPull == 1'b0, "R10 sda released at end", sdaPull, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule